// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When a burst starts, it captures an external address as its base. After that it replaces only the two lowest address bits as the beats go by. The upper bits stay as they were captured.

A static order input selects one of two beat orders. The interleaved order exclusive-ORs the beat index into the starting low bits. The linear order adds the beat index to the starting low bits, modulo four. Advancing steps to the next beat. Holding advance low freezes the burst for any number of cycles. After the fourth beat, the sequence returns to the starting address. A new load at any time restarts the sequence from a fresh base.

The start and step pulses come already decoded from the surrounding control logic. The address and beat outputs are registered state. They change one clock edge after the pulse that causes the change, except when the order input itself changes.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and right after it, `addr_o` is 0 and `beat_o` is 0.
- R2: A clock edge with `load_i` high makes `addr_o` equal the `addr_i` sampled at that edge, and sets `beat_o` to 0, from the next cycle on.
- R3: A clock edge with `adv_i` high and `load_i` low increments `beat_o` modulo 4. The step from beat 3 wraps to beat 0, which shows the starting address again.
- R4: A clock edge with both `load_i` and `adv_i` low leaves `beat_o` and `addr_o` unchanged, for as many cycles as it lasts, as long as `mode_i` is stable.
- R5: With `mode_i` = 1 (interleaved), `addr_o[1:0]` equals the starting low bits XOR `beat_o`. For example, a start at 01 gives 01, 00, 11, 10.
- R6: With `mode_i` = 0 (linear), `addr_o[1:0]` equals (starting low bits + `beat_o`) modulo 4. For example, a start at 11 gives 11, 00, 01, 10.
- R7: `addr_o[ADDR_W-1:2]` always equals the upper bits of the most recently loaded address, and advancing never changes them.
- R8: When `load_i` and `adv_i` are both high at the same edge, the load wins: the new base appears with `beat_o` = 0.
- R9: A load in the middle of a burst restarts the sequence at beat 0 from the new base address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a burst from `addr_i` |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Beat order: 1 selects interleaved, 0 selects linear |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | 2 | Index of the current beat, 0 to 3 |

## Verification
A start and a step can fall on the same clock edge. The bench provokes this by raising `load_i` and `adv_i` together, both at the start of a burst and in the middle of one. It then judges that the new base appears at beat 0 rather than the old burst advancing. A reload in the middle of a burst without a step is driven as well, and after it the sequence is followed through the hold and wrap cases. Every starting low value is run in both orders against the scoreboard's own arithmetic.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LO_W = 2;
  localparam int BEATS = 1 << LO_W;

  typedef logic [LO_W-1:0] lo_t;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // beat k of an interleaved burst: start bits with k folded in by XOR
  function automatic lo_t ilv_lo(lo_t start, lo_t k);
    return start ^ k;
  endfunction

  // beat k of a linear burst: start bits plus k, wrapping at BEATS
  function automatic lo_t lin_lo(lo_t start, lo_t k);
    return lo_t'(start + k);
  endfunction

  function automatic lo_t next_beat(lo_t k);
    return lo_t'(k + lo_t'(1));
  endfunction
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_o <= '0;
    end else if (load_evt) begin
      base_o <= addr_i;
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_evt,
  input  logic step_evt,
  output lo_t  beat_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_o <= '0;
    end else if (load_evt) begin
      beat_o <= '0;
    end else if (step_evt) begin
      beat_o <= next_beat(beat_o);
    end
  end
endmodule

// File: rtl/burst_lo_map.sv
module burst_lo_map
  import burst_seq_pkg::*;
(
  input  lo_t  start_lo,
  input  lo_t  beat,
  input  logic mode_i,
  output lo_t  lo_o
);
  localparam int N_ORD = 2;

  lo_t cand [N_ORD];

  for (genvar o = 0; o < N_ORD; o++) begin : g_ord
    if (o == int'(ORD_INTERLEAVE)) begin : g_ilv
      assign cand[o] = ilv_lo(start_lo, beat);
    end else begin : g_lin
      assign cand[o] = lin_lo(start_lo, beat);
    end
  end

  order_e ord;
  assign ord  = order_e'(mode_i);
  assign lo_o = (ord == ORD_INTERLEAVE) ? cand[int'(ORD_INTERLEAVE)]
                                        : cand[int'(ORD_LINEAR)];
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LO_W-1:0]   beat_o
);
  localparam int HI_W = ADDR_W - LO_W;

  // named events, visible to the bound checker
  logic load_evt;
  logic step_evt;
  assign load_evt = load_i;
  assign step_evt = adv_i & ~load_i;

  logic [ADDR_W-1:0] base;
  lo_t               beat;
  lo_t               cur_lo;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .addr_i   (addr_i),
    .base_o   (base)
  );

  burst_beat_ctr u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .beat_o   (beat)
  );

  burst_lo_map u_map (
    .start_lo (base[LO_W-1:0]),
    .beat     (beat),
    .mode_i   (mode_i),
    .lo_o     (cur_lo)
  );

  assign addr_o = {base[ADDR_W-1 -: HI_W], cur_lo};
  assign beat_o = beat;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              adv_i,
  input logic              mode_i,
  input logic              step_evt,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        beat_o
);
  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(addr_i)) && (beat_o == 2'd0)); // R2

  AST_LOAD_BEATS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && adv_i) |=> (beat_o == 2'd0)); // R8

  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (beat_o == 2'($past(beat_o) + 2'd1))); // R3

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(beat_o)); // R4

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(addr_o[ADDR_W-1:2])); // R7

  AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && mode_i) |=> (!mode_i ||
      ((addr_o[1:0] ^ $past(addr_o[1:0])) == (beat_o ^ $past(beat_o))))); // R5

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !mode_i) |=> (mode_i ||
      (addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1)))); // R6
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_i   (load_i),
  .adv_i    (adv_i),
  .mode_i   (mode_i),
  .step_evt (step_evt),
  .addr_i   (addr_i),
  .addr_o   (addr_o),
  .beat_o   (beat_o)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          mode_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
    .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    beat;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   m_base = 0;
  int   m_beat = 0;
  bit   done = 0;

  function automatic logic [AW-1:0] model_addr(int base, int beat, bit ilv);
    int lo;
    int hi;
    hi = base - (base % 4);
    lo = base % 4;
    if (ilv) lo = ((lo / 2 == beat / 2) ? 0 : 2) + ((lo % 2 == beat % 2) ? 0 : 1);
    else     lo = (lo + beat) % 4;
    return AW'(hi + lo);
  endfunction

  task automatic check(logic [AW-1:0] a, logic [1:0] b, exp_t e);
    n_chk++;
    if (a !== e.addr || b !== e.beat) begin
      n_bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               e.tag, a, b, e.addr, e.beat);
    end
  endtask

  // driver: one cycle of stimulus, expectation pushed for the next edge
  task automatic cyc(bit ld, bit ad, int a, string tag);
    exp_t e;
    @(negedge clk);
    load_i = ld;
    adv_i  = ad;
    addr_i = AW'(a);
    if (ld) begin
      m_base = a;
      m_beat = 0;
    end else if (ad) begin
      m_beat = (m_beat + 1) % 4;
    end
    e.addr = model_addr(m_base, m_beat, mode_i);
    e.beat = 2'(m_beat);
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // monitor: a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(addr_o, beat_o, e);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    exp_t r;
    r.addr = '0; r.beat = '0; r.tag = "R1 reset";
    #(CLK_PERIOD * 2 + 2);
    check(addr_o, beat_o, r);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check(addr_o, beat_o, r);

    for (int m = 1; m >= 0; m--) begin
      @(negedge clk);
      mode_i = m[0];
      for (int s = 0; s < 4; s++) begin
        int a;
        a = (((s * 37 + m * 11) % 4096) << 2) + s + 'h20000 * m;
        cyc(1, 0, a, "R2 load");
        cyc(0, 1, 0, m ? "R5 R7 interleaved step" : "R6 R7 linear step");
        cyc(0, 0, 0, "R4 hold");
        cyc(0, 0, 0, "R4 hold");
        cyc(0, 1, 0, m ? "R5 interleaved step" : "R6 linear step");
        cyc(0, 1, 0, m ? "R5 interleaved step" : "R6 linear step");
        cyc(0, 1, 0, "R3 wrap to start");
        cyc(0, 1, 0, "R3 after wrap");
      end
      cyc(1, 1, 'h1_2346, "R8 load with advance");
      cyc(0, 1, 0, "R3 step after R8");
      cyc(0, 1, 0, "R3 step");
      cyc(1, 0, 'h2_ABC1, "R9 reload mid burst");
      cyc(0, 1, 0, "R9 step after reload");
      cyc(1, 1, 'h0_0FF3, "R8 R9 reload with advance mid burst");
      cyc(0, 0, 0, "R4 hold after reload");
      cyc(0, 1, 0, "R7 step keeps upper bits");
    end
    cyc(0, 0, 0, "R4 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule